// File: doc/BRIEF.md
# Tree Sweep Prefix-Sum Unit

This block takes N operands in parallel and returns all N inclusive running sums, where lane i of the result holds the sum of operands 0 through i, wrapped to the word width. It computes these sums on a complete binary tree of combining registers. Each clock the tree advances one level or performs one whole fix-up step. A small sequencer drives the steps in a fixed order:

- an upward fan-in that stops at the two nodes just below the root;
- a fix-up inside each pair of sibling leaves;
- a sibling exchange that leaves the identity value in every internal left child;
- a downward pass in which each child adds its parent's value.

A client drives a vector of operands, pulses start for one cycle, and waits for the one-cycle done pulse. The result then stays on the output until the client issues another start. The operator is addition modulo 2^W, with zero as the identity. N must be a power of two of at least 4, and both N and W are parameters that elaboration checks.

Top module: `pfx_scan`

## Requirements
- R1: Lane i of `opnd_in` is bits [i*W +: W], and lane 0 is the first operand. When done is high, lane i of `prefix_out` (bits [i*W +: W]) equals the sum of operand lanes 0..i.
- R2: Every sum wraps modulo 2^W. Overflow is discarded and causes no other effect.
- R3: done rises exactly 2*log2(N)+2 clock cycles after the rising clock edge that accepts start. With the defaults (N=8) this is 8 cycles. done stays low in every cycle in between.
- R4: done is high for exactly one cycle per accepted start.
- R5: A start that arrives while a computation is in progress is ignored. The operands presented with it do not change the result, and the timing of done does not change.
- R6: While the unit is idle and start is low, `prefix_out` holds its value, whatever `opnd_in` does.
- R7: A synchronous active-high reset returns the unit to idle with done low. A computation that is in flight is abandoned and never signals done. A start in the first cycle after reset is accepted.
- R8: A start presented in the same cycle as done is accepted, so computations can run back to back without an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Single-cycle request that captures `opnd_in` when the unit is idle |
| opnd_in | input | N*W | Packed operand lanes, lane 0 in the low bits |
| prefix_out | output | N*W | Packed inclusive prefix sums, lane 0 in the low bits |
| done | output | 1 | Pulses for one cycle when `prefix_out` holds a finished result |

## Verification
On every cycle the checker confirms several properties:

- the distance from an accepted start to done;
- that done lasts a single cycle;
- that the output holds while the unit is idle;
- that the unit returns to idle after reset;
- that every finished output matches a running sum of the operands captured at acceptance.

Only the bench's scenarios show that a start during a computation is really discarded, including the junk operands presented with it. The same holds for an abandoned computation staying silent after a reset in mid-sweep, and for a start that coincides with done beginning a new computation on time. The bench covers wrap-around through all-ones, half-range and single-lane sweeps together with random vectors.

// File: rtl/pfx_scan_pkg.sv
package pfx_scan_pkg;

   typedef enum logic [2:0] {
      OP_IDLE,
      OP_LOAD,
      OP_UP,
      OP_PAIR,
      OP_SWAP,
      OP_DOWN,
      OP_HOLD
   } scan_op_e;

   // depth of a heap-indexed node: node 1 is the root at depth 0
   function automatic int node_depth(input int idx);
      int d;
      d = 0;
      for (int v = idx; v > 1; v = v / 2) d++;
      return d;
   endfunction

endpackage

// File: rtl/pfx_scan_seq.sv
module pfx_scan_seq
   import pfx_scan_pkg::*;
#(
   parameter int LEVELS = 3
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            start,
   output logic            busy,
   output logic            done,
   output scan_op_e        op,
   output logic [$clog2(LEVELS+1)-1:0] lvl
);
   localparam int STEPS = 2 * LEVELS + 2;
   localparam int CW    = $clog2(STEPS + 1);
   localparam int LW    = $clog2(LEVELS + 1);

   logic [CW-1:0] cnt_q;
   logic          busy_q;
   logic          done_q;
   int            c_i;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (start) begin
               busy_q <= 1'b1;
               cnt_q  <= '0;
            end
         end else begin
            cnt_q <= cnt_q + 1'b1;
            if (int'(cnt_q) == STEPS - 1) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   // step map: up-sweep, pair fix-up + hold, swap + hold, down-sweep
   always_comb begin
      c_i = int'(cnt_q);
      op  = OP_IDLE;
      lvl = '0;
      if (!busy_q) begin
         op = start ? OP_LOAD : OP_IDLE;
      end else if (c_i < LEVELS - 1) begin
         op  = OP_UP;
         lvl = LW'(LEVELS - 1 - c_i);
      end else if (c_i == LEVELS - 1) begin
         op = OP_PAIR;
      end else if (c_i == LEVELS + 1) begin
         op = OP_SWAP;
      end else if (c_i == LEVELS || c_i == LEVELS + 2) begin
         op = OP_HOLD;
      end else begin
         op  = OP_DOWN;
         lvl = LW'(c_i - LEVELS - 1);
      end
   end

   assign busy = busy_q;
   assign done = done_q;

endmodule

// File: rtl/pfx_scan_tree.sv
module pfx_scan_tree
   import pfx_scan_pkg::*;
#(
   parameter int NUM   = 8,
   parameter int WIDTH = 16
) (
   input  logic                   clk,
   input  logic                   rst,
   input  scan_op_e               op,
   input  logic [$clog2($clog2(NUM)+1)-1:0] lvl,
   input  logic [NUM*WIDTH-1:0]   opnd,
   output logic [NUM*WIDTH-1:0]   leaves
);
   localparam int LEVELS = $clog2(NUM);
   localparam int LW     = $clog2(LEVELS + 1);
   localparam logic [WIDTH-1:0] IDENT = '0;

   logic [WIDTH-1:0] node_q [NUM];
   logic [WIDTH-1:0] node_d [NUM];
   logic [WIDTH-1:0] leaf_q [NUM];
   logic [WIDTH-1:0] leaf_d [NUM];

   assign node_d[0] = IDENT;
   assign node_d[1] = IDENT;

   // internal nodes below the root, heap indexed 2..NUM-1
   for (genvar k = 2; k < NUM; k++) begin : g_node
      localparam int DEP = node_depth(k);
      logic [WIDTH-1:0] up_v;
      logic [WIDTH-1:0] swap_v;
      logic [WIDTH-1:0] down_v;

      if (2 * k < NUM) begin : g_up_inner
         assign up_v = node_q[2*k] + node_q[2*k+1];
      end else begin : g_up_leaf
         assign up_v = leaf_q[2*k-NUM] + leaf_q[2*k+1-NUM];
      end

      if (k % 2 == 1) begin : g_right
         assign swap_v = node_q[k-1];
      end else begin : g_left
         assign swap_v = IDENT;
      end

      if (k >= 4) begin : g_dn
         assign down_v = node_q[k] + node_q[k/2];
      end else begin : g_top
         assign down_v = node_q[k];
      end

      assign node_d[k] = (op == OP_UP   && lvl == LW'(DEP)) ? up_v   :
                         (op == OP_SWAP)                    ? swap_v :
                         (op == OP_DOWN && lvl == LW'(DEP)) ? down_v :
                                                              node_q[k];
   end

   // leaves: operand storage and result lanes
   for (genvar j = 0; j < NUM; j++) begin : g_leaf
      logic [WIDTH-1:0] pair_v;
      logic [WIDTH-1:0] down_v;

      if (j % 2 == 1) begin : g_rchild
         assign pair_v = leaf_q[j-1] + leaf_q[j];
      end else begin : g_lchild
         assign pair_v = leaf_q[j];
      end

      assign down_v = leaf_q[j] + node_q[(NUM+j)/2];

      assign leaf_d[j] = (op == OP_LOAD)                           ? opnd[j*WIDTH +: WIDTH] :
                         (op == OP_PAIR)                           ? pair_v :
                         (op == OP_DOWN && lvl == LW'(LEVELS))     ? down_v :
                                                                     leaf_q[j];
      assign leaves[j*WIDTH +: WIDTH] = leaf_q[j];
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < NUM; i++) begin
         if (rst) begin
            node_q[i] <= IDENT;
            leaf_q[i] <= IDENT;
         end else begin
            node_q[i] <= node_d[i];
            leaf_q[i] <= leaf_d[i];
         end
      end
   end

endmodule

// File: rtl/pfx_scan.sv
module pfx_scan
   import pfx_scan_pkg::*;
#(
   parameter int N = 8,
   parameter int W = 16
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           start,
   input  logic [N*W-1:0] opnd_in,
   output logic [N*W-1:0] prefix_out,
   output logic           done
);
   localparam int LEVELS = $clog2(N);
   localparam int LW     = $clog2(LEVELS + 1);

   if (N < 4 || (N & (N - 1)) != 0) begin : g_bad_n
      $error("pfx_scan: N must be a power of two and at least 4");
   end
   if (W < 1) begin : g_bad_w
      $error("pfx_scan: W must be at least 1");
   end

   scan_op_e       op;
   logic [LW-1:0]  lvl;
   logic           busy;

   pfx_scan_seq #(.LEVELS(LEVELS)) u_seq (
      .clk   (clk),
      .rst   (rst),
      .start (start),
      .busy  (busy),
      .done  (done),
      .op    (op),
      .lvl   (lvl)
   );

   pfx_scan_tree #(.NUM(N), .WIDTH(W)) u_tree (
      .clk    (clk),
      .rst    (rst),
      .op     (op),
      .lvl    (lvl),
      .opnd   (opnd_in),
      .leaves (prefix_out)
   );

endmodule

// File: rtl/pfx_scan_chk.sv
module pfx_scan_chk #(
   parameter int N = 8,
   parameter int W = 16
) (
   input logic           clk,
   input logic           rst,
   input logic           start,
   input logic           busy,
   input logic           done,
   input logic [N*W-1:0] opnd_in,
   input logic [N*W-1:0] prefix_out
);
   localparam int STEPS = 2 * $clog2(N) + 2;
   localparam int AW    = $clog2(STEPS + 2) + 1;

   logic [AW-1:0]  age;
   logic           live;
   logic [N*W-1:0] want_d;
   logic [N*W-1:0] want_q;

   always_comb begin
      logic [W-1:0] acc;
      acc = '0;
      for (int i = 0; i < N; i++) begin
         acc = acc + opnd_in[i*W +: W];
         want_d[i*W +: W] = acc;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         live   <= 1'b0;
         age    <= '0;
         want_q <= '0;
      end else if (start && !busy) begin
         live   <= 1'b1;
         age    <= '0;
         want_q <= want_d;
      end else if (live && int'(age) <= STEPS) begin
         age <= age + 1'b1;
      end
   end

   AST_PREFIX_MATCH: assert property (@(posedge clk) disable iff (rst)
      done |-> prefix_out == want_q);                                   // R1
   AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst)
      done |-> (live && int'(age) == STEPS));                            // R3
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);                                                   // R4
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!busy && !start) |=> $stable(prefix_out));                        // R6
   AST_RESET_IDLE: assert property (@(posedge clk)
      rst |=> (!done && !busy));                                         // R7

endmodule

bind pfx_scan pfx_scan_chk #(.N(N), .W(W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .start      (start),
   .busy       (busy),
   .done       (done),
   .opnd_in    (opnd_in),
   .prefix_out (prefix_out)
);

// File: tb/pfx_scan_bench.sv
module pfx_scan_bench;
   localparam int N          = 8;
   localparam int W          = 16;
   localparam int LAT        = 2 * $clog2(N) + 2;
   localparam int CLK_PERIOD = 10;

   logic           clk = 1'b0;
   logic           rst;
   logic           start;
   logic [N*W-1:0] opnd_in;
   logic [N*W-1:0] prefix_out;
   logic           done;

   int n_cmp = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pfx_scan #(.N(N), .W(W)) u_pfx_scan (
      .clk        (clk),
      .rst        (rst),
      .start      (start),
      .opnd_in    (opnd_in),
      .prefix_out (prefix_out),
      .done       (done)
   );

   function automatic logic [N*W-1:0] scan_ref(input logic [N*W-1:0] v);
      logic [N*W-1:0] r;
      logic [W-1:0]   acc;
      acc = '0;
      for (int i = 0; i < N; i++) begin
         acc = acc + v[i*W +: W];
         r[i*W +: W] = acc;
      end
      return r;
   endfunction

   function automatic logic [N*W-1:0] rand_vec();
      logic [N*W-1:0] v;
      for (int i = 0; i < N; i++) v[i*W +: W] = W'($urandom);
      return v;
   endfunction

   task automatic check(input bit ok, input string tag,
                        input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // call at a negedge; returns at the negedge where done should be high
   task automatic run_op(input logic [N*W-1:0] v, input int inj,
                         input logic [N*W-1:0] junk, input string tag);
      int hit;
      hit = -1;
      opnd_in = v;
      start   = 1'b1;
      for (int i = 0; i <= LAT; i++) begin
         @(negedge clk);
         if (done && hit < 0) hit = i;
         if (i == 0) start = 1'b0;
         if (i == inj) begin
            start   = 1'b1;
            opnd_in = junk;
         end else if (i == inj + 1) begin
            start = 1'b0;
         end
      end
      start = 1'b0;
      check(hit == LAT, {"R3 latency ", tag}, (N*W)'(hit), (N*W)'(LAT));
      check(prefix_out == scan_ref(v), {"R1 prefix ", tag}, prefix_out, scan_ref(v));
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [N*W-1:0] v;
      logic [N*W-1:0] held;
      bit             quiet;

      rst     = 1'b1;
      start   = 1'b0;
      opnd_in = '0;
      repeat (3) @(negedge clk);
      check(done == 1'b0, "R7 done low in reset", (N*W)'(done), '0);
      rst = 1'b0;

      // R7: start in the first cycle after reset; R2 all-ones wrap
      run_op({N{16'hFFFF}}, -1, '0, "R2 R7 all-ones");
      // R8: start coincides with done
      for (int i = 0; i < N; i++) v[i*W +: W] = W'(i + 1);
      run_op(v, -1, '0, "R8 back-to-back ascending");
      run_op({N{16'h8000}}, -1, '0, "R2 half-range overflow");

      // R4: done drops after one cycle
      @(negedge clk);
      check(done == 1'b0, "R4 single-cycle done", (N*W)'(done), '0);

      // R6: idle output holds while operands change
      held  = prefix_out;
      quiet = 1'b1;
      for (int i = 0; i < 6; i++) begin
         opnd_in = rand_vec();
         @(negedge clk);
         if (prefix_out != held || done) quiet = 1'b0;
      end
      check(quiet, "R6 idle hold", prefix_out, held);

      // R5: start during the sweep at several points
      run_op(rand_vec(), 1, {N{16'h1234}}, "R5 early restart");
      run_op(rand_vec(), 3, {N{16'hFFFF}}, "R5 mid restart");
      run_op(rand_vec(), LAT - 1, {N{16'h0F0F}}, "R5 late restart");

      // R7: reset in mid-sweep abandons the computation
      @(negedge clk);
      opnd_in = rand_vec();
      start   = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (2) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst   = 1'b0;
      quiet = 1'b1;
      for (int i = 0; i < LAT + 3; i++) begin
         @(negedge clk);
         if (done) quiet = 1'b0;
      end
      check(quiet, "R7 abandoned sweep silent", (N*W)'(!quiet), '0);
      run_op({N{16'h7FFF}}, -1, '0, "R7 R2 after mid reset");

      // R1: single-lane sweep over each position and edge values
      for (int j = 0; j < N; j++) begin
         foreach (v[b]) v[b] = 1'b0;
         v[j*W +: W] = 16'h0001;
         run_op(v, -1, '0, "R1 single lane one");
         v[j*W +: W] = 16'hFFFF;
         run_op(v, -1, '0, "R1 single lane max");
         v[j*W +: W] = 16'h8000;
         run_op(v, -1, '0, "R2 single lane msb");
      end

      // R1: random vectors
      for (int k = 0; k < 300; k++) begin
         run_op(rand_vec(), -1, '0, "R1 random");
      end

      @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule